// File: doc/BRIEF.md
# Processor Halt Request Controller

This block gathers every condition that can stop a processor core for debug and turns them into one halted state. A double fault and a halt instruction stop the core on the next clock edge. A hardware-breakpoint trigger and the external breakpoint pin only leave a pending request. That request is honoured at the core's once-per-instruction sample strobe, so the stop lands on an instruction boundary that is not exact. When several requests are live in the same cycle, a fixed ranking picks the winner. The winner is recorded as a 2-bit cause that can be read while the core is stopped.

While halted, the 4-bit processor-status output is forced to all ones. While running, that output passes the core's own status code through unchanged. A halt instruction issued in user mode stops the core only when the user-halt-enable bit is set. Without that bit, the block raises a privilege-violation request instead. A go input returns the controller to running one cycle after it is seen.

The controller is a two-state machine. `ST_RUN` moves to `ST_HALTED` when a halt is taken (transition TAKE). `ST_HALTED` moves back to `ST_RUN` on go (transition RESUME). `ST_HALTED` stays put otherwise (transition HOLD), and `ST_RUN` stays put when no halt is taken (transition IDLE).

Top module: `halt_ctl`

## Requirements
- R1: After reset the outputs are as follows: `halted_o`=0, `priv_viol_o`=0, `cause_o`=0, and `status_o` equals `core_status_i`. Reset also discards any pending request.
- R2: A double-fault input seen while running sets `halted_o` on the next edge with cause 2'd0, whether or not the sample strobe is present.
- R3: A hardware-breakpoint trigger while running is held as a pending request. It halts the core on the edge that follows a cycle with `sample_i`=1, with cause 2'd1. A trigger in the same cycle as the sample counts.
- R4: The breakpoint pin (active high) is held as a pending request in the same way. It halts the core at a sample point with cause 2'd3.
- R5: A halt-instruction strobe with `user_mode_i`=0 halts the core on the next edge with cause 2'd2, without waiting for a sample.
- R6: A halt-instruction strobe with `user_mode_i`=1 and the following effects:
  - With `uhe_i`=1 it halts like R5.
  - With `uhe_i`=0 it does not halt. Instead `priv_viol_o` pulses for exactly one cycle after it, unless another source takes a halt in the same cycle.
- R7: When several halt sources are live in one cycle, the winner is the first in this order: double fault, sampled hardware breakpoint, allowed halt instruction, sampled breakpoint pin.
- R8: While halted, `status_o` is 4'hF. While running, `status_o` equals `core_status_i`.
- R9: Entering the halted state clears every pending request. A request that lost arbitration therefore does not halt the core again after resume.
- R10: `go_i` while halted drops `halted_o` on the next edge, and `cause_o` then reads 0.
- R11: While halted, all halt sources are ignored. The core stays halted with `cause_o` unchanged, and no pending request is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbl_fault_i | input | 1 | Fault-on-fault indication |
| hw_bkpt_i | input | 1 | Hardware-breakpoint trigger |
| halt_insn_i | input | 1 | Decoded halt-instruction strobe |
| user_mode_i | input | 1 | 1 = core in user mode |
| bkpt_pin_i | input | 1 | External breakpoint pin, active high |
| sample_i | input | 1 | Once-per-instruction halt sample strobe |
| uhe_i | input | 1 | Allow halt instruction in user mode |
| go_i | input | 1 | Leave halted state |
| core_status_i | input | 4 | Core's normal processor-status code |
| halted_o | output | 1 | Core is halted |
| status_o | output | 4 | Processor-status output |
| priv_viol_o | output | 1 | Privilege-violation exception request |
| cause_o | output | 2 | Halt cause (0 fault, 1 hw bkpt, 2 insn, 3 pin) |

## Verification
The bench targets several corner cases:
- A pending breakpoint that has not yet been sampled losing to a halt instruction. A design with the ranking reversed would report cause 3 instead of 2.
- The lost request after resume. A design that keeps pending flags across the halt would stop again at the first sample.
- A breakpoint pin pulse while halted. A design that latches during halt would stop again after go.
- A user-mode halt instruction against the enable bit, including a same-cycle sampled breakpoint. A wrong design would halt where it should not, or flag a violation while halting.
- A reset with a request pending. A design that does not clear on reset would halt at the next sample.

// File: rtl/halt_ctl_pkg.sv
package halt_ctl_pkg;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } hstate_t;

    // Cause code equals the rank of the source; lower wins.
    typedef enum logic [1:0] {
        CAUSE_FAULT = 2'd0,
        CAUSE_HWBP  = 2'd1,
        CAUSE_INSN  = 2'd2,
        CAUSE_PIN   = 2'd3
    } cause_t;

    localparam int N_SRC   = 4;
    localparam int CAUSE_W = $clog2(N_SRC);
    localparam int N_PEND  = 2;  // deferred sources: hw breakpoint, pin

endpackage

// File: rtl/halt_pend.sv
module halt_pend
    import halt_ctl_pkg::*;
#(
    parameter int N = N_PEND
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] eff_o
);

    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (clr_i) begin
                pend_q[i] <= 1'b0;
            end else if (en_i && set_i[i]) begin
                pend_q[i] <= 1'b1;
            end
        end

        // A request arriving in the sample cycle itself is already visible.
        assign eff_o[i] = pend_q[i] | (en_i & set_i[i]);
    end

endmodule

// File: rtl/halt_arb.sv
module halt_arb
    import halt_ctl_pkg::*;
(
    input  logic               run_i,
    input  logic               fault_i,
    input  logic               hwbp_eff_i,
    input  logic               insn_ok_i,
    input  logic               pin_eff_i,
    input  logic               sample_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic [N_SRC-1:0] req;

    always_comb begin
        req                  = '0;
        req[int'(CAUSE_FAULT)] = fault_i;
        req[int'(CAUSE_HWBP)]  = hwbp_eff_i & sample_i;
        req[int'(CAUSE_INSN)]  = insn_ok_i;
        req[int'(CAUSE_PIN)]   = pin_eff_i & sample_i;
        req                  = run_i ? req : '0;
    end

    always_comb begin
        take_o  = |req;
        cause_o = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (req[k]) begin
                cause_o = CAUSE_W'(k);
            end
        end
    end

endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
    import halt_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               go_i,
    input  logic               viol_i,
    output logic               run_o,
    output logic               halted_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               priv_o
);

    hstate_t            state_q, state_d;
    logic [CAUSE_W-1:0] cause_q;
    logic               priv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= '0;
            priv_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && take_i) begin
                cause_q <= cause_i;
            end
            priv_q <= (state_q == ST_RUN) && viol_i && !take_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (take_i) state_d = ST_HALTED;  // TAKE
            ST_HALTED: if (go_i)   state_d = ST_RUN;     // RESUME
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o    = 1'b0;
        halted_o = 1'b0;
        cause_o  = '0;
        unique case (state_q)
            ST_RUN:    run_o = 1'b1;
            ST_HALTED: begin
                halted_o = 1'b1;
                cause_o  = cause_q;
            end
            default:   run_o = 1'b1;
        endcase
        priv_o = priv_q;
    end

endmodule

// File: rtl/halt_ctl.sv
module halt_ctl
    import halt_ctl_pkg::*;
#(
    parameter int STATUS_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dbl_fault_i,
    input  logic                hw_bkpt_i,
    input  logic                halt_insn_i,
    input  logic                user_mode_i,
    input  logic                bkpt_pin_i,
    input  logic                sample_i,
    input  logic                uhe_i,
    input  logic                go_i,
    input  logic [STATUS_W-1:0] core_status_i,
    output logic                halted_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                priv_viol_o,
    output logic [1:0]          cause_o
);

    localparam logic [STATUS_W-1:0] HALT_CODE = '1;

    logic               run;
    logic               take;
    logic [CAUSE_W-1:0] arb_cause;
    logic [CAUSE_W-1:0] fsm_cause;
    logic [N_PEND-1:0]  pend_eff;
    logic               insn_ok;
    logic               insn_viol;

    assign insn_ok   = halt_insn_i & (~user_mode_i | uhe_i);
    assign insn_viol = halt_insn_i & user_mode_i & ~uhe_i;

    halt_pend #(.N(N_PEND)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (run),
        .clr_i (take),
        .set_i ({bkpt_pin_i, hw_bkpt_i}),
        .eff_o (pend_eff)
    );

    halt_arb u_arb (
        .run_i      (run),
        .fault_i    (dbl_fault_i),
        .hwbp_eff_i (pend_eff[0]),
        .insn_ok_i  (insn_ok),
        .pin_eff_i  (pend_eff[1]),
        .sample_i   (sample_i),
        .take_o     (take),
        .cause_o    (arb_cause)
    );

    halt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .cause_i  (arb_cause),
        .go_i     (go_i),
        .viol_i   (insn_viol),
        .run_o    (run),
        .halted_o (halted_o),
        .cause_o  (fsm_cause),
        .priv_o   (priv_viol_o)
    );

    assign cause_o  = 2'(fsm_cause);
    assign status_o = halted_o ? HALT_CODE : core_status_i;

endmodule

// File: rtl/halt_ctl_chk.sv
module halt_ctl_chk #(
    parameter int STATUS_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dbl_fault_i,
    input logic                halt_insn_i,
    input logic                user_mode_i,
    input logic                sample_i,
    input logic                uhe_i,
    input logic                go_i,
    input logic [STATUS_W-1:0] core_status_i,
    input logic                halted_o,
    input logic [STATUS_W-1:0] status_o,
    input logic                priv_viol_o,
    input logic [1:0]          cause_o
);

    p_fault_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && dbl_fault_i) |=> (halted_o && cause_o == 2'd0));

    p_wait_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && !dbl_fault_i && !halt_insn_i && !sample_i) |=> !halted_o);

    p_insn_super_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && halt_insn_i && !user_mode_i) |=> halted_o);

    p_viol_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && halt_insn_i && user_mode_i && !uhe_i && !dbl_fault_i && !sample_i)
        |=> (priv_viol_o && !halted_o));

    p_viol_not_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol_o |-> !halted_o);

    p_status_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> status_o == '1);

    p_status_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !halted_o |-> status_o == core_status_i);

    p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && go_i) |=> (!halted_o && cause_o == 2'd0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !go_i) |=> (halted_o && $stable(cause_o)));

endmodule

bind halt_ctl halt_ctl_chk #(.STATUS_W(STATUS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbl_fault_i   (dbl_fault_i),
    .halt_insn_i   (halt_insn_i),
    .user_mode_i   (user_mode_i),
    .sample_i      (sample_i),
    .uhe_i         (uhe_i),
    .go_i          (go_i),
    .core_status_i (core_status_i),
    .halted_o      (halted_o),
    .status_o      (status_o),
    .priv_viol_o   (priv_viol_o),
    .cause_o       (cause_o)
);

// File: tb/tb_halt_ctl.sv
module tb_halt_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbl_fault_i = 0, hw_bkpt_i = 0, halt_insn_i = 0, user_mode_i = 0;
    logic       bkpt_pin_i = 0, sample_i = 0, uhe_i = 0, go_i = 0;
    logic [3:0] core_status_i = 4'h0;
    logic       halted_o, priv_viol_o;
    logic [3:0] status_o;
    logic [1:0] cause_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;  // 250 MHz

    halt_ctl dut (.*);

    // in: [7]fault [6]hw [5]insn [4]user [3]pin [2]sample [1]uhe [0]go
    typedef struct packed {
        logic [7:0] in;
        logic [3:0] cs;
        logic       halted;
        logic       priv;
        logic [1:0] cause;
        logic [3:0] st;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{8'b0000_0000, 4'h3, 1'b0, 1'b0, 2'd0, 4'h3, 8'd1 },  // R8 pass
        '{8'b0100_0000, 4'h5, 1'b0, 1'b0, 2'd0, 4'h5, 8'd3 },  // R3 pend
        '{8'b0000_0000, 4'h6, 1'b0, 1'b0, 2'd0, 4'h6, 8'd3 },
        '{8'b0000_0100, 4'h6, 1'b1, 1'b0, 2'd1, 4'hF, 8'd3 },  // R3 sample
        '{8'b0000_0000, 4'h6, 1'b1, 1'b0, 2'd1, 4'hF, 8'd8 },
        '{8'b1000_0000, 4'h6, 1'b1, 1'b0, 2'd1, 4'hF, 8'd11},  // R11
        '{8'b0000_0001, 4'h2, 1'b0, 1'b0, 2'd0, 4'h2, 8'd10},  // R10
        '{8'b0000_1000, 4'h2, 1'b0, 1'b0, 2'd0, 4'h2, 8'd4 },  // R4 pend
        '{8'b0010_0100, 4'h2, 1'b1, 1'b0, 2'd2, 4'hF, 8'd7 },  // R7 insn over pin
        '{8'b0000_0001, 4'hA, 1'b0, 1'b0, 2'd0, 4'hA, 8'd10},
        '{8'b0000_0100, 4'hA, 1'b0, 1'b0, 2'd0, 4'hA, 8'd9 },  // R9
        '{8'b0011_0000, 4'h7, 1'b0, 1'b1, 2'd0, 4'h7, 8'd6 },  // R6 viol
        '{8'b0000_0000, 4'h7, 1'b0, 1'b0, 2'd0, 4'h7, 8'd6 },
        '{8'b0011_0010, 4'h7, 1'b1, 1'b0, 2'd2, 4'hF, 8'd6 },  // R6 uhe
        '{8'b0000_0001, 4'h1, 1'b0, 1'b0, 2'd0, 4'h1, 8'd10},
        '{8'b1110_1100, 4'h1, 1'b1, 1'b0, 2'd0, 4'hF, 8'd7 },  // R7 fault
        '{8'b0000_0001, 4'h4, 1'b0, 1'b0, 2'd0, 4'h4, 8'd10},
        '{8'b0100_1100, 4'h4, 1'b1, 1'b0, 2'd1, 4'hF, 8'd7 },  // R7 hw over pin
        '{8'b0000_0001, 4'h4, 1'b0, 1'b0, 2'd0, 4'h4, 8'd10},
        '{8'b0000_1100, 4'h4, 1'b1, 1'b0, 2'd3, 4'hF, 8'd4 },  // R4
        '{8'b0000_1000, 4'h4, 1'b1, 1'b0, 2'd3, 4'hF, 8'd11},  // R11
        '{8'b0000_0001, 4'h9, 1'b0, 1'b0, 2'd0, 4'h9, 8'd10},
        '{8'b0000_0100, 4'h9, 1'b0, 1'b0, 2'd0, 4'h9, 8'd11},  // R11 nothing latched
        '{8'b0111_0100, 4'h9, 1'b1, 1'b0, 2'd1, 4'hF, 8'd6 },  // R6 suppressed
        '{8'b1000_0001, 4'h8, 1'b0, 1'b0, 2'd0, 4'h8, 8'd10}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] in, input logic [3:0] cs);
        {dbl_fault_i, hw_bkpt_i, halt_insn_i, user_mode_i,
         bkpt_pin_i, sample_i, uhe_i, go_i} = in;
        core_status_i = cs;
    endtask

    task automatic check_all(input string req, input logic h, input logic p,
                             input logic [1:0] c, input logic [3:0] s);
        chk(req, "halted_o", int'(halted_o), int'(h));
        chk(req, "priv_viol_o", int'(priv_viol_o), int'(p));
        chk(req, "cause_o", int'(cause_o), int'(c));
        chk(req, "status_o", int'(status_o), int'(s));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        apply(8'h00, 4'hC);
        repeat (3) @(negedge clk);
        check_all("R1", 1'b0, 1'b0, 2'd0, 4'hC);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0, 1'b0, 2'd0, 4'hC);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            @(negedge clk);
            apply(VECS[i].in, VECS[i].cs);
            @(posedge clk);
            #1;
            check_all(tag, VECS[i].halted, VECS[i].priv, VECS[i].cause, VECS[i].st);
        end

        // R1: reset discards a pending hardware breakpoint
        @(negedge clk);
        apply(8'b0100_0000, 4'h5);
        @(negedge clk);
        apply(8'h00, 4'h5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        apply(8'b0000_0100, 4'h5);
        @(posedge clk);
        #1;
        check_all("R1 pend-reset", 1'b0, 1'b0, 2'd0, 4'h5);

        // R3: pending held across many idle cycles until sample
        @(negedge clk);
        apply(8'b0100_0000, 4'h2);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            apply(8'h00, 4'h2);
            @(posedge clk);
            #1;
            chk("R3 idle", "halted_o", int'(halted_o), 0);
        end
        @(negedge clk);
        apply(8'b0000_0100, 4'h2);
        @(posedge clk);
        #1;
        check_all("R3 late sample", 1'b1, 1'b0, 2'd1, 4'hF);

        // R5: supervisor halt instruction without sample
        @(negedge clk);
        apply(8'b0000_0001, 4'h3);
        @(negedge clk);
        apply(8'b0010_0000, 4'h3);
        @(posedge clk);
        #1;
        check_all("R5", 1'b1, 1'b0, 2'd2, 4'hF);

        // R2: fault with no sample
        @(negedge clk);
        apply(8'b0000_0001, 4'h3);
        @(negedge clk);
        apply(8'b1000_0000, 4'h3);
        @(posedge clk);
        #1;
        check_all("R2", 1'b1, 1'b0, 2'd0, 4'hF);

        @(negedge clk);
        apply(8'h00, 4'h3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule